// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block loads a target FPGA through its slave-serial configuration pins. A start pulse makes it pull the target's active-low configuration-reset line and wait for the target's clearing indicator. It then releases the line, waits for the target to finish clearing and checks that the target's "configured" pin reads low. After a fixed programming latency it shifts image bytes, taken from an upstream valid/ready byte stream, out on a serial clock and data pair.

When the last image byte has gone out, the block samples the configured pin and then sends one all-ones padding byte per sample. It stops once a padding byte has followed a sample that saw the pin high. If the completion window runs out first, the block reads the clearing indicator to tell a CRC or device fault apart from a missing sync word or a short image. Only a busy flag, a success flag and a 3-bit result code are reported.

The two target inputs pass through two-flop synchronisers. A build parameter selects whether the clearing indicator is fitted at all. When it is not fitted, fixed delays stand in for both level waits.

Top module: `cfgld_seq`

## Requirements
- R1: After reset, the configuration-reset output is high, the serial clock is low, and busy, success, the result code and stream ready are all 0.
- R2: A start pulse with `partial_i` high, taken while idle, sets the result code to 1 (invalid request) on the next cycle. Busy stays low and the configuration-reset output never goes low.
- R3: An accepted start drives the configuration-reset output low for at least PULSE_MIN cycles. When sensing is fitted, the output also stays low until the synchronised clearing input reads low. No serial clock edge occurs while the output is low.
- R4: If the clearing input has not gone low within LEVEL_TMO cycles, the configuration-reset output is released and result code 2 (level timeout) is posted in the same cycle.
- R5: After release, if the clearing input has not returned high within LEVEL_TMO cycles, result code 2 is posted.
- R6: With sensing not fitted (HAS_CLR_SENSE = 0), the clearing input is ignored. The low pulse lasts at least the larger of PULSE_MIN and ALT_DLY cycles, and the release wait is skipped.
- R7: If the synchronised configured input is high once clearing has ended, result code 3 (unexpected configured state) is posted and no serial clock edge occurs.
- R8: At least LATENCY_CYC cycles pass between the release of the configuration-reset output and the first serial clock rising edge.
- R9: Each byte is sent MSB first as 8 serial clock pulses, each high for CCLK_HALF cycles and low for CCLK_HALF cycles. Data changes only while the clock is low, and the clock idles low.
- R10: Stream ready is high only while streaming with the serialiser idle. Each accepted byte yields exactly 8 rising edges, and the byte taken with `s_last_i` high ends the image.
- R11: After the image, each completion step samples the configured input and then sends one 0xFF byte. If that sample was high, success is posted with code 0. The total rising-edge count is therefore 8 × (image bytes + padding bytes).
- R12: A step whose sample was taken at or after CPL_TMO cycles of padding, and found the configured input low, ends the run after its padding byte. The code is 4 if the clearing input is low (asserted), 5 if it is high, and 6 if sensing is not fitted. At least one padding byte is always sent.
- R13: Busy is high from the accepted start until the result is posted. Start pulses are ignored while busy. The success flag and result code hold until the next start pulse taken while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| partial_i | input | 1 | Partial-reconfiguration flag qualifying start |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Image byte accepted when high with valid |
| tgt_cfg_rst_no | output | 1 | Active-low configuration reset to the target |
| tgt_clr_ni | input | 1 | Target clearing indicator, low = asserted (asynchronous) |
| tgt_loaded_i | input | 1 | Target configured indicator (asynchronous) |
| ser_clk_o | output | 1 | Serial configuration clock |
| ser_dat_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Load completed successfully |
| err_o | output | 3 | Result code, 0 = none |

## Verification
The load sequence is run with a target model. In some runs the model answers normally; in others it never asserts clearing, never releases it, reports configured too early, or stays unconfigured while holding the clearing line at either level. Each run ends with a different result code. Two successful images differ in content, length and in when the configured pin rises, which separates the count of padding bytes (2 or 3) and shows the MSB-first bit order. A second instance without clearing sense is held with that input asserted, which shows the input is ignored. The same instance has a zero completion window, which shows that exactly one padding byte is sent before a generic timeout.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int TMR_W  = 32;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int ERR_W  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PGM_LOW,
        ST_WAIT_HI,
        ST_CHK_LOADED,
        ST_LATENCY,
        ST_STREAM,
        ST_DRAIN,
        ST_PAD_SMP,
        ST_PAD_WAIT
    } seq_state_e;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE     = 3'd0,
        ERR_BAD_REQ  = 3'd1,
        ERR_LVL_TMO  = 3'd2,
        ERR_EARLY    = 3'd3,
        ERR_CRC      = 3'd4,
        ERR_SYNC     = 3'd5,
        ERR_TMO      = 3'd6
    } seq_err_e;

    typedef struct packed {
        seq_state_e        state;
        logic [TMR_W-1:0]  cnt;
        logic [TMR_W-1:0]  cpl;
        logic              busy;
        logic              ok;
        seq_err_e          err;
        logic              pgm_n;
        logic              smp_loaded;
        logic              smp_exp;
    } seq_regs_t;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
    import cfgld_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              idle_o,
    output logic              end_o,
    output logic              sclk_o,
    output logic              sdat_o
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              act;
        logic              hi;
        logic [BIT_W-1:0]  idx;
        logic [DIV_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
    } shift_regs_t;

    shift_regs_t sr_d, sr_q;
    logic        term;

    assign term = (sr_q.cnt == DIV_LAST);

    always_comb begin
        sr_d = sr_q;
        if (!sr_q.act) begin
            if (load_i) begin
                sr_d.act = 1'b1;
                sr_d.hi  = 1'b0;
                sr_d.idx = '0;
                sr_d.cnt = '0;
                sr_d.sh  = byte_i;
            end
        end else begin
            sr_d.cnt = sr_q.cnt + 1'b1;
            if (term) begin
                sr_d.cnt = '0;
                if (!sr_q.hi) begin
                    sr_d.hi = 1'b1;
                end else begin
                    sr_d.hi = 1'b0;
                    if (sr_q.idx == BIT_LAST) begin
                        sr_d.act = 1'b0;
                    end else begin
                        sr_d.idx = sr_q.idx + 1'b1;
                        sr_d.sh  = {sr_q.sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign idle_o = !sr_q.act;
    assign end_o  = sr_q.act && sr_q.hi && term && (sr_q.idx == BIT_LAST);
    assign sclk_o = sr_q.act && sr_q.hi;
    assign sdat_o = sr_q.act && sr_q.sh[BYTE_W-1];
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int CCLK_HALF     = 4,
    parameter int PULSE_MIN     = 125,
    parameter int LEVEL_TMO     = 250_000_000,
    parameter int LATENCY_CYC   = 1_875_000,
    parameter int ALT_DLY       = 250,
    parameter int CPL_TMO       = 250_000,
    parameter bit HAS_CLR_SENSE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              partial_i,
    input  logic [BYTE_W-1:0] s_data_i,
    input  logic              s_valid_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              tgt_cfg_rst_no,
    input  logic              tgt_clr_ni,
    input  logic              tgt_loaded_i,
    output logic              ser_clk_o,
    output logic              ser_dat_o,
    output logic              busy_o,
    output logic              ok_o,
    output logic [ERR_W-1:0]  err_o
);
    localparam int FIX_PULSE = (PULSE_MIN > ALT_DLY) ? PULSE_MIN : ALT_DLY;
    localparam logic [TMR_W-1:0] PULSE_L = TMR_W'(PULSE_MIN);
    localparam logic [TMR_W-1:0] FIX_L   = TMR_W'(FIX_PULSE);
    localparam logic [TMR_W-1:0] LVL_L   = TMR_W'(LEVEL_TMO);
    localparam logic [TMR_W-1:0] LAT_L   = TMR_W'(LATENCY_CYC - 1);
    localparam logic [TMR_W-1:0] CPL_L   = TMR_W'(CPL_TMO);

    seq_regs_t         q, d;
    logic              clr_s;
    logic              loaded_s;
    logic              ser_load;
    logic [BYTE_W-1:0] ser_byte;
    logic              ser_idle;
    logic              ser_end;

    cfgld_sync #(.W(1), .RST_VAL(1'b0)) u_sync_loaded (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (tgt_loaded_i),
        .q_o    (loaded_s)
    );

    if (HAS_CLR_SENSE) begin : g_clr_sense
        cfgld_sync #(.W(1), .RST_VAL(1'b1)) u_sync_clr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (tgt_clr_ni),
            .q_o    (clr_s)
        );
    end else begin : g_clr_fixed
        logic unused_clr;
        assign unused_clr = tgt_clr_ni;
        assign clr_s      = 1'b1;
    end

    cfgld_shift #(.HALF(CCLK_HALF)) u_shift (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ser_load),
        .byte_i (ser_byte),
        .idle_o (ser_idle),
        .end_o  (ser_end),
        .sclk_o (ser_clk_o),
        .sdat_o (ser_dat_o)
    );

    always_comb begin
        d         = q;
        ser_load  = 1'b0;
        ser_byte  = s_data_i;
        s_ready_o = 1'b0;
        if (q.cnt != '1) d.cnt = q.cnt + 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.ok = 1'b0;
                    if (partial_i) begin
                        d.err = ERR_BAD_REQ;
                    end else begin
                        d.err   = ERR_NONE;
                        d.busy  = 1'b1;
                        d.pgm_n = 1'b0;
                        d.state = ST_PGM_LOW;
                    end
                end
            end
            ST_PGM_LOW: begin
                if (HAS_CLR_SENSE) begin
                    if (!clr_s && (q.cnt >= PULSE_L)) begin
                        d.pgm_n = 1'b1;
                        d.state = ST_WAIT_HI;
                    end else if (q.cnt >= LVL_L) begin
                        d.pgm_n = 1'b1;
                        d.busy  = 1'b0;
                        d.err   = ERR_LVL_TMO;
                        d.state = ST_IDLE;
                    end
                end else if (q.cnt >= FIX_L) begin
                    d.pgm_n = 1'b1;
                    d.state = ST_WAIT_HI;
                end
            end
            ST_WAIT_HI: begin
                if (clr_s) begin
                    d.state = ST_CHK_LOADED;
                end else if (q.cnt >= LVL_L) begin
                    d.busy  = 1'b0;
                    d.err   = ERR_LVL_TMO;
                    d.state = ST_IDLE;
                end
            end
            ST_CHK_LOADED: begin
                if (loaded_s) begin
                    d.busy  = 1'b0;
                    d.err   = ERR_EARLY;
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_LATENCY;
                end
            end
            ST_LATENCY: begin
                if (q.cnt >= LAT_L) d.state = ST_STREAM;
            end
            ST_STREAM: begin
                s_ready_o = ser_idle;
                if (s_valid_i && ser_idle) begin
                    ser_load = 1'b1;
                    if (s_last_i) d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                d.cpl = '0;
                if (ser_end) d.state = ST_PAD_SMP;
            end
            ST_PAD_SMP: begin
                ser_load     = 1'b1;
                ser_byte     = '1;
                d.smp_loaded = loaded_s;
                d.smp_exp    = (q.cpl >= CPL_L);
                d.state      = ST_PAD_WAIT;
            end
            ST_PAD_WAIT: begin
                if (ser_end) begin
                    if (q.smp_loaded) begin
                        d.busy  = 1'b0;
                        d.ok    = 1'b1;
                        d.state = ST_IDLE;
                    end else if (q.smp_exp) begin
                        d.busy  = 1'b0;
                        d.state = ST_IDLE;
                        if (!HAS_CLR_SENSE) d.err = ERR_TMO;
                        else if (!clr_s)    d.err = ERR_CRC;
                        else                d.err = ERR_SYNC;
                    end else begin
                        d.state = ST_PAD_SMP;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if ((q.state == ST_PAD_SMP || q.state == ST_PAD_WAIT) && (q.cpl != '1))
            d.cpl = q.cpl + 1'b1;
        if (d.state != q.state) d.cnt = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q            <= '0;
            q.state      <= ST_IDLE;
            q.err        <= ERR_NONE;
            q.pgm_n      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tgt_cfg_rst_no = q.pgm_n;
    assign busy_o         = q.busy;
    assign ok_o           = q.ok;
    assign err_o          = q.err;
endmodule

// File: rtl/cfgld_seq_chk.sv
module cfgld_seq_chk #(
    parameter int PULSE_MIN = 1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic       partial_i,
    input logic       s_ready_o,
    input logic       tgt_cfg_rst_no,
    input logic       ser_clk_o,
    input logic       ser_dat_o,
    input logic       busy_o,
    input logic       ok_o,
    input logic [2:0] err_o
);
    logic [31:0] low_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              low_cnt_q <= '0;
        else if (tgt_cfg_rst_no)  low_cnt_q <= '0;
        else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
    end

    p_bad_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && partial_i && !busy_o) |=> (err_o == 3'd1 && tgt_cfg_rst_no && !busy_o));

    p_pulse_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tgt_cfg_rst_no) |-> (low_cnt_q >= 32'(PULSE_MIN)));

    p_no_clk_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tgt_cfg_rst_no |-> !ser_clk_o);

    p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_clk_o |-> $stable(ser_dat_o));

    p_clk_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !ser_clk_o);

    p_ready_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ready_o |-> (busy_o && !ser_clk_o));

    p_status_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o != 3'd0) |-> (!ok_o && !busy_o));

    p_status_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(ok_o)));
endmodule

bind cfgld_seq cfgld_seq_chk #(.PULSE_MIN(PULSE_MIN)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .partial_i      (partial_i),
    .s_ready_o      (s_ready_o),
    .tgt_cfg_rst_no (tgt_cfg_rst_no),
    .ser_clk_o      (ser_clk_o),
    .ser_dat_o      (ser_dat_o),
    .busy_o         (busy_o),
    .ok_o           (ok_o),
    .err_o          (err_o)
);

// File: tb/cfgld_seq_tb_top.sv
module cfgld_seq_mon #(
    parameter int HALF = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         pgm_n,
    input  logic         sclk,
    input  logic         sdat,
    input  logic         rdy,
    output int           edges,
    output int           low_cyc,
    output int           lat,
    output int           bad_hi,
    output int           bad_dat,
    output int           rdy_seen,
    output logic [511:0] bits
);
    logic p_clk = 1'b0;
    logic p_dat = 1'b0;
    logic p_pgm = 1'b1;
    int   hi_run = 0;
    int   lat_cnt = 0;
    bit   lat_on = 1'b0;

    initial begin
        edges = 0; low_cyc = 0; lat = -1; bad_hi = 0; bad_dat = 0; rdy_seen = 0; bits = '0;
    end

    always @(negedge clk) begin
        if (clr) begin
            edges = 0; low_cyc = 0; lat = -1; bad_hi = 0; bad_dat = 0; rdy_seen = 0;
            bits = '0; hi_run = 0; lat_on = 1'b0;
        end else begin
            if (!pgm_n) low_cyc++;
            if (rdy) rdy_seen++;
            if (lat_on) lat_cnt++;
            if (pgm_n && !p_pgm) begin lat_on = 1'b1; lat_cnt = 0; end
            if (sclk && !p_clk) begin
                if (edges < 512) bits[edges] = sdat;
                edges++;
                if (lat_on) begin lat = lat_cnt; lat_on = 1'b0; end
            end
            if (sclk) hi_run++;
            else if (p_clk) begin
                if (hi_run != HALF) bad_hi++;
                hi_run = 0;
            end
            if (sclk && p_clk && (sdat != p_dat)) bad_dat++;
        end
        p_clk = sclk; p_dat = sdat; p_pgm = pgm_n;
    end
endmodule

module cfgld_seq_tb_top;
    localparam int HALF = 2;
    localparam int PMIN = 20;
    localparam int LVL  = 200;
    localparam int LAT  = 50;
    localparam int ALT  = 30;
    localparam int CPL  = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic       start_a = 0, part_a = 0, val_a = 0, last_a = 0;
    logic [7:0] dat_a = 0;
    logic       rdy_a, pgm_a, sclk_a, sdat_a, busy_a, ok_a;
    logic [2:0] err_a;
    logic       clrpin_a, ldpin_a;

    logic       start_b = 0, part_b = 0, val_b = 0, last_b = 0;
    logic [7:0] dat_b = 0;
    logic       rdy_b, pgm_b, sclk_b, sdat_b, busy_b, ok_b;
    logic [2:0] err_b;
    logic       ldpin_b;
    logic       clrpin_b = 1'b0;

    logic mclr = 1'b0;
    int e_a, lc_a, lat_a, bh_a, bd_a, rs_a;
    int e_b, lc_b, lat_b, bh_b, bd_b, rs_b;
    logic [511:0] bits_a, bits_b;

    bit k_no_assert = 0, k_no_deassert = 0, k_early = 0, k_fail_clr = 1;
    int k_img = 0, k_ld_at = 0;
    bit k2_ld = 0;

    cfgld_seq #(
        .CCLK_HALF(HALF), .PULSE_MIN(PMIN), .LEVEL_TMO(LVL), .LATENCY_CYC(LAT),
        .ALT_DLY(ALT), .CPL_TMO(CPL), .HAS_CLR_SENSE(1'b1)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .partial_i(part_a),
        .s_data_i(dat_a), .s_valid_i(val_a), .s_last_i(last_a), .s_ready_o(rdy_a),
        .tgt_cfg_rst_no(pgm_a), .tgt_clr_ni(clrpin_a), .tgt_loaded_i(ldpin_a),
        .ser_clk_o(sclk_a), .ser_dat_o(sdat_a), .busy_o(busy_a), .ok_o(ok_a), .err_o(err_a)
    );

    cfgld_seq #(
        .CCLK_HALF(HALF), .PULSE_MIN(PMIN), .LEVEL_TMO(LVL), .LATENCY_CYC(LAT),
        .ALT_DLY(ALT), .CPL_TMO(0), .HAS_CLR_SENSE(1'b0)
    ) dut_ns_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .partial_i(part_b),
        .s_data_i(dat_b), .s_valid_i(val_b), .s_last_i(last_b), .s_ready_o(rdy_b),
        .tgt_cfg_rst_no(pgm_b), .tgt_clr_ni(clrpin_b), .tgt_loaded_i(ldpin_b),
        .ser_clk_o(sclk_b), .ser_dat_o(sdat_b), .busy_o(busy_b), .ok_o(ok_b), .err_o(err_b)
    );

    cfgld_seq_mon #(.HALF(HALF)) mon_a (
        .clk(clk), .clr(mclr), .pgm_n(pgm_a), .sclk(sclk_a), .sdat(sdat_a), .rdy(rdy_a),
        .edges(e_a), .low_cyc(lc_a), .lat(lat_a), .bad_hi(bh_a), .bad_dat(bd_a),
        .rdy_seen(rs_a), .bits(bits_a)
    );

    cfgld_seq_mon #(.HALF(HALF)) mon_b (
        .clk(clk), .clr(mclr), .pgm_n(pgm_b), .sclk(sclk_b), .sdat(sdat_b), .rdy(rdy_b),
        .edges(e_b), .low_cyc(lc_b), .lat(lat_b), .bad_hi(bh_b), .bad_dat(bd_b),
        .rdy_seen(rs_b), .bits(bits_b)
    );

    // target model for the sensing instance
    always @(posedge clk) begin
        if (!rst_n) begin
            clrpin_a <= 1'b1;
            ldpin_a  <= 1'b0;
        end else begin
            if (!pgm_a)                           clrpin_a <= k_no_assert;
            else if (k_no_deassert)               clrpin_a <= 1'b0;
            else if (k_img > 0 && e_a >= 8*k_img) clrpin_a <= k_fail_clr;
            else                                  clrpin_a <= 1'b1;
            ldpin_a <= k_early || (k_ld_at != 0 && e_a >= k_ld_at);
        end
    end

    // target model for the instance without clearing sense
    always @(posedge clk) begin
        if (!rst_n) ldpin_b <= 1'b0;
        else        ldpin_b <= k2_ld && (e_b >= 4);
    end

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep(input bit na, input bit nd, input bit early, input bit fclr,
                        input int img, input int ldat, input bit ld2);
        @(negedge clk);
        k_no_assert = na; k_no_deassert = nd; k_early = early; k_fail_clr = fclr;
        k_img = img; k_ld_at = ldat; k2_ld = ld2;
        @(posedge clk); mclr = 1'b1;
        @(posedge clk); mclr = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_start(input bit b, input bit p);
        @(negedge clk);
        if (b) begin start_b = 1; part_b = p; end else begin start_a = 1; part_a = p; end
        @(negedge clk);
        start_a = 0; part_a = 0; start_b = 0; part_b = 0;
    endtask

    task automatic feed(input bit b, input logic [31:0] img, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (b) begin val_b = 1; dat_b = img[31-8*i -: 8]; last_b = (i == n-1); end
            else   begin val_a = 1; dat_a = img[31-8*i -: 8]; last_a = (i == n-1); end
            while (!(b ? rdy_b : rdy_a)) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        val_a = 0; last_a = 0; val_b = 0; last_b = 0;
    endtask

    task automatic wait_idle(input bit b);
        int n = 0;
        while ((b ? busy_b : busy_a) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk(1'b0, "R13 busy never cleared", n, 0);
        @(negedge clk);
    endtask

    task automatic chk_stream_bits(input bit b, input logic [31:0] img, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < 8*n; i++)
            if ((b ? bits_b[i] : bits_a[i]) != img[31-i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic chk_pad_ones(input bit b, input int from, input string req);
        int bad = 0;
        int top = b ? e_b : e_a;
        for (int i = from; i < top && i < 512; i++)
            if (!(b ? bits_b[i] : bits_a[i])) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(pgm_a == 1 && pgm_b == 1, "R1 cfg reset high", pgm_a, 1);
        chk(sclk_a == 0 && rdy_a == 0, "R1 serial clock/ready low", sclk_a, 0);
        chk(busy_a == 0 && ok_a == 0 && err_a == 0, "R1 status clear", {busy_a, ok_a, err_a}, 0);
    endtask

    task automatic t_partial();
        prep(0, 0, 0, 1, 0, 0, 0);
        pulse_start(0, 1);
        @(negedge clk);
        chk(err_a == 3'd1, "R2 invalid request code", err_a, 1);
        chk(busy_a == 0, "R2 busy stays low", busy_a, 0);
        repeat (10) @(negedge clk);
        chk(lc_a == 0, "R2 cfg reset never low", lc_a, 0);
        chk(err_a == 3'd1, "R13 code holds while idle", err_a, 1);
    endtask

    task automatic t_ok1();
        logic [31:0] img = 32'hA53C8100;
        prep(0, 0, 0, 1, 3, 28, 0);
        pulse_start(0, 0);
        chk(busy_a == 1, "R13 busy after start", busy_a, 1);
        repeat (4) @(negedge clk);
        pulse_start(0, 0);
        fork
            feed(0, img, 3);
            wait_idle(0);
        join
        chk(ok_a == 1 && err_a == 0, "R11 success posted", {ok_a, err_a}, 8);
        chk(e_a == 40, "R11 two padding bytes", e_a, 40);
        chk_stream_bits(0, img, 3, "R9 image MSB first");
        chk_pad_ones(0, 24, "R11 padding all ones");
        chk(lc_a >= PMIN, "R3 pulse width", lc_a, PMIN);
        chk(lat_a >= LAT, "R8 programming latency", lat_a, LAT);
        chk(bh_a == 0, "R9 clock high width", bh_a, 0);
        chk(bd_a == 0, "R9 data stable while clock high", bd_a, 0);
        chk(e_a % 8 == 0, "R10 whole bytes", e_a % 8, 0);
        repeat (10) @(negedge clk);
        chk(ok_a == 1, "R13 success holds", ok_a, 1);
    endtask

    task automatic t_ok2();
        logic [31:0] img = 32'h00000000;
        prep(0, 0, 0, 1, 1, 19, 0);
        pulse_start(0, 0);
        fork
            feed(0, img, 1);
            wait_idle(0);
        join
        chk(ok_a == 1 && err_a == 0, "R11 success, late configured", {ok_a, err_a}, 8);
        chk(e_a == 32, "R11 three padding bytes", e_a, 32);
        chk_stream_bits(0, img, 1, "R9 zero byte");
        chk_pad_ones(0, 8, "R11 padding all ones");
    endtask

    task automatic t_no_assert();
        prep(1, 0, 0, 1, 0, 0, 0);
        pulse_start(0, 0);
        wait_idle(0);
        chk(err_a == 3'd2, "R4 level timeout code", err_a, 2);
        chk(pgm_a == 1, "R4 cfg reset released", pgm_a, 1);
        chk(lc_a >= LVL, "R3 held low until clearing seen", lc_a, LVL);
        chk(e_a == 0, "R3 no serial clock", e_a, 0);
    endtask

    task automatic t_no_deassert();
        prep(0, 1, 0, 1, 0, 0, 0);
        pulse_start(0, 0);
        wait_idle(0);
        chk(err_a == 3'd2, "R5 release wait timeout", err_a, 2);
        chk(pgm_a == 1 && e_a == 0, "R5 released, no clock", e_a, 0);
    endtask

    task automatic t_early();
        prep(0, 0, 1, 1, 0, 0, 0);
        pulse_start(0, 0);
        wait_idle(0);
        chk(err_a == 3'd3, "R7 unexpected configured code", err_a, 3);
        chk(e_a == 0, "R7 no serial clock", e_a, 0);
        chk(rs_a == 0, "R10 ready never raised", rs_a, 0);
    endtask

    task automatic t_fail(input bit clr_level, input int exp_code, input string req);
        logic [31:0] img = 32'h99000000;
        prep(0, 0, 0, clr_level, 1, 0, 0);
        pulse_start(0, 0);
        fork
            feed(0, img, 1);
            wait_idle(0);
        join
        chk(err_a == exp_code[2:0] && ok_a == 0, req, err_a, exp_code);
        chk(e_a >= 8 + 8*(CPL/(16*HALF)), "R12 padding until window ends", e_a, 8 + 8*(CPL/(16*HALF)));
        chk_pad_ones(0, 8, "R12 padding all ones");
    endtask

    task automatic t_ns_ok();
        logic [31:0] img = 32'hC35A0000;
        prep(0, 0, 0, 1, 0, 0, 1);
        pulse_start(1, 0);
        fork
            feed(1, img, 2);
            wait_idle(1);
        join
        chk(ok_b == 1 && err_b == 0, "R6 success with clearing ignored", {ok_b, err_b}, 8);
        chk(lc_b >= ALT, "R6 fixed pulse width", lc_b, ALT);
        chk(e_b == 24, "R11 single padding byte", e_b, 24);
        chk_stream_bits(1, img, 2, "R9 two-byte image");
    endtask

    task automatic t_ns_tmo();
        logic [31:0] img = 32'h7E000000;
        prep(0, 0, 0, 1, 0, 0, 0);
        pulse_start(1, 0);
        fork
            feed(1, img, 1);
            wait_idle(1);
        join
        chk(err_b == 3'd6, "R12 generic timeout code", err_b, 6);
        chk(e_b == 16, "R12 exactly one padding byte", e_b, 16);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_partial();
        t_ok1();
        t_ok2();
        t_no_assert();
        t_no_deassert();
        t_early();
        t_fail(1'b0, 4, "R12 CRC fault code");
        t_fail(1'b1, 5, "R12 sync/short image code");
        t_ns_ok();
        t_ns_tmo();
        finish_run();
    end
endmodule